// File: doc/BRIEF.md
# Banked Parallel Dot-Product Engine

This block forms the signed dot product of two 64-element vectors, one of data and one of coefficients. Both vectors are held in external memory banks, eight for data and eight for coefficients. Each vector is split into contiguous blocks, so each bank holds eight neighbouring elements. After a start request the engine reads one data word and one coefficient word from every bank in each cycle. It multiplies the eight pairs side by side in eight lanes. A fully registered balanced tree of seven adders then reduces the eight products, and one accumulator adder sums the tree results across the eight issue cycles.

The banks themselves sit outside the block. They share one local read address and one read strobe, and each bank returns its word one clock after the strobe. When the last partial sum has left the pipeline, the engine registers the 32-bit result and raises a one-cycle done pulse. The result then stays unchanged until the next run completes.

Top module: `dp8_engine`

## Requirements
- R1: After a run, `result` equals the sum over i = 0..63 of data[i] * coef[i], computed modulo 2^32.
- R2: Bank k holds elements 8k..8k+7 at local addresses 0..7. Its read word appears on bits [32k+31:32k] of `data_bank_q` and `coef_bank_q`. Lane k multiplies the data slice k by the coefficient slice k.
- R3: After start is accepted, `rd_en` is high for exactly 8 consecutive cycles with `rd_addr` = 0,1,..,7. The first of these cycles is the one right after the accepting edge. Each bank returns the word for an address on the clock edge that samples that address with `rd_en` high.
- R4: `done` is high for exactly one cycle, in the 13th cycle after the edge that accepted start. That is 8 issue cycles plus 5 pipeline stages: bank read, multiply and three tree levels.
- R5: `busy` is high from the cycle after the accepting edge until `done` rises, and low in the done cycle. While `busy` is high, `start` is ignored and the running computation is unaffected.
- R6: `result` changes only in the cycle where `done` is high, and holds at all other times, including when bank contents change. The accumulator clears on each accepted start, so consecutive runs are independent.
- R7: During and right after reset, `busy`, `done` and `rd_en` are 0 and `result` is 0.
- R8: Products and sums keep only their low 32 bits, so overflow wraps.
- R9: Operands are two's-complement signed, so negative data and coefficients give signed products.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Request a new dot product; accepted only when idle |
| data_bank_q | input | 256 | Read words of the eight data banks, bank k in bits [32k+31:32k] |
| coef_bank_q | input | 256 | Read words of the eight coefficient banks, same layout |
| rd_en | output | 1 | Read strobe shared by all sixteen banks |
| rd_addr | output | 3 | Local bank address shared by all banks |
| busy | output | 1 | Run in progress |
| done | output | 1 | One-cycle pulse when `result` is updated |
| result | output | 32 | Registered dot product |

## Verification
The bench walks every cycle of a run and checks the address sequence and the exact done cycle. An engine with one register too few or too many in the tree, or with a misaligned valid pipeline, would pulse done early or late, or would sum stale products. Single-element probes at bank boundaries (elements 0, 7, 8, 19, 56, 63) expose lanes that pair data from one bank with coefficients from another. Wrapping and negative operands catch sign or width slips. A start pulse in mid-run, a second run on fresh data, and bank changes while idle show whether the accumulator clears and whether the result register leaks.

// File: rtl/dp8_pkg.sv
package dp8_pkg;
  // Run sequencer states
  typedef enum logic [1:0] {
    SEQ_IDLE  = 2'd0,
    SEQ_ISSUE = 2'd1,
    SEQ_DRAIN = 2'd2
  } seq_state_e;
endpackage

// File: rtl/dp8_sequencer.sv
module dp8_sequencer
  import dp8_pkg::*;
#(
  parameter int unsigned DEPTH = 8,
  parameter int unsigned AW    = 3,
  parameter int unsigned PIPE  = 5
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  output logic          run_accept,
  output logic          rd_en,
  output logic [AW-1:0] rd_addr,
  output logic          busy,
  output logic          data_vld,
  output logic          root_vld,
  output logic          root_last
);

  seq_state_e      state_q;
  logic [AW-1:0]   cnt_q;
  logic [PIPE-1:0] vld_sr;
  logic [PIPE-1:0] last_sr;
  logic            issue;
  logic            last_issue;

  assign issue      = (state_q == SEQ_ISSUE);
  assign last_issue = issue && (cnt_q == AW'(DEPTH - 1));
  assign run_accept = start && (state_q == SEQ_IDLE);
  assign rd_en      = issue;
  assign rd_addr    = cnt_q;
  assign busy       = (state_q != SEQ_IDLE);
  assign data_vld   = vld_sr[0];
  assign root_vld   = vld_sr[PIPE-1];
  assign root_last  = last_sr[PIPE-1];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= SEQ_IDLE;
      cnt_q   <= '0;
    end else begin
      case (state_q)
        SEQ_IDLE: begin
          if (run_accept) begin
            state_q <= SEQ_ISSUE;
            cnt_q   <= '0;
          end
        end
        SEQ_ISSUE: begin
          cnt_q <= cnt_q + 1'b1;
          if (last_issue) state_q <= SEQ_DRAIN;
        end
        SEQ_DRAIN: begin
          if (root_last) state_q <= SEQ_IDLE;
        end
        default: state_q <= SEQ_IDLE;
      endcase
    end
  end

  // Valid and last tags travel alongside the operands: read, multiply, tree levels
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      vld_sr  <= '0;
      last_sr <= '0;
    end else begin
      vld_sr  <= {vld_sr[PIPE-2:0], issue};
      last_sr <= {last_sr[PIPE-2:0], last_issue};
    end
  end

endmodule

// File: rtl/dp8_mul_lane.sv
module dp8_mul_lane #(
  parameter int unsigned DW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          en,
  input  logic [DW-1:0] a,
  input  logic [DW-1:0] b,
  output logic [DW-1:0] prod
);

  // Signed product truncated to the operand width (wraps)
  function automatic logic [DW-1:0] lane_prod(input logic [DW-1:0] x, input logic [DW-1:0] y);
    logic signed [2*DW-1:0] full;
    full = $signed(x) * $signed(y);
    return full[DW-1:0];
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n)  prod <= '0;
    else if (en) prod <= lane_prod(a, b);
  end

endmodule

// File: rtl/dp8_add_tree.sv
module dp8_add_tree #(
  parameter int unsigned DW    = 32,
  parameter int unsigned LANES = 8   // power of two
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [LANES*DW-1:0] leaves,
  output logic [DW-1:0]       root
);

  localparam int unsigned NODES = 2 * LANES - 1;
  localparam int unsigned INNER = LANES - 1;

  // Heap layout: node i has children 2i+1 and 2i+2; leaves occupy INNER..NODES-1
  logic [DW-1:0] node_q [INNER];
  logic [DW-1:0] all_n  [NODES];

  function automatic logic [DW-1:0] tree_add(input logic [DW-1:0] x, input logic [DW-1:0] y);
    return x + y;
  endfunction

  always_comb begin
    for (int i = 0; i < NODES; i++) begin
      if (i < INNER) all_n[i] = node_q[i];
      else           all_n[i] = leaves[(i - INNER) * DW +: DW];
    end
  end

  // Every inner node is a register, so each tree level is one pipeline stage
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < INNER; i++) node_q[i] <= '0;
    end else begin
      for (int i = 0; i < INNER; i++) node_q[i] <= tree_add(all_n[2*i+1], all_n[2*i+2]);
    end
  end

  assign root = node_q[0];

endmodule

// File: rtl/dp8_engine.sv
module dp8_engine #(
  parameter int unsigned DW      = 32,
  parameter int unsigned VEC_LEN = 64,
  parameter int unsigned LANES   = 8
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       start,
  input  logic [LANES*DW-1:0]        data_bank_q,
  input  logic [LANES*DW-1:0]        coef_bank_q,
  output logic                       rd_en,
  output logic [$clog2(VEC_LEN/LANES)-1:0] rd_addr,
  output logic                       busy,
  output logic                       done,
  output logic [DW-1:0]              result
);

  localparam int unsigned DEPTH  = VEC_LEN / LANES;
  localparam int unsigned AW     = $clog2(DEPTH);
  localparam int unsigned LEVELS = $clog2(LANES);
  localparam int unsigned PIPE   = 2 + LEVELS;

  logic                run_accept;
  logic                data_vld;
  logic                root_vld;
  logic                root_last;
  logic [LANES*DW-1:0] prod_flat;
  logic [DW-1:0]       root_sum;
  logic [DW-1:0]       acc_q;
  logic [DW-1:0]       acc_next;

  function automatic logic [DW-1:0] acc_add(input logic [DW-1:0] x, input logic [DW-1:0] y);
    return x + y;
  endfunction

  dp8_sequencer #(.DEPTH(DEPTH), .AW(AW), .PIPE(PIPE)) u_seq (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (start),
    .run_accept(run_accept),
    .rd_en     (rd_en),
    .rd_addr   (rd_addr),
    .busy      (busy),
    .data_vld  (data_vld),
    .root_vld  (root_vld),
    .root_last (root_last)
  );

  for (genvar k = 0; k < LANES; k++) begin : g_lane
    dp8_mul_lane #(.DW(DW)) u_lane (
      .clk  (clk),
      .rst_n(rst_n),
      .en   (data_vld),
      .a    (data_bank_q[k*DW +: DW]),
      .b    (coef_bank_q[k*DW +: DW]),
      .prod (prod_flat[k*DW +: DW])
    );
  end

  dp8_add_tree #(.DW(DW), .LANES(LANES)) u_tree (
    .clk   (clk),
    .rst_n (rst_n),
    .leaves(prod_flat),
    .root  (root_sum)
  );

  assign acc_next = acc_add(acc_q, root_sum);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      acc_q  <= '0;
      result <= '0;
      done   <= 1'b0;
    end else begin
      done <= 1'b0;
      if (run_accept)    acc_q <= '0;
      else if (root_vld) acc_q <= acc_next;
      if (root_vld && root_last) begin
        result <= acc_next;
        done   <= 1'b1;
      end
    end
  end

endmodule

// File: rtl/dp8_engine_chk.sv
module dp8_engine_chk #(
  parameter int unsigned DW    = 32,
  parameter int unsigned DEPTH = 8,
  parameter int unsigned AW    = 3,
  parameter int unsigned PIPE  = 5
) (
  input logic          clk,
  input logic          rst_n,
  input logic          start,
  input logic          run_accept,
  input logic          rd_en,
  input logic [AW-1:0] rd_addr,
  input logic          busy,
  input logic          done,
  input logic [DW-1:0] result
);

  localparam int unsigned CW = AW + 1;
  localparam int unsigned LW = $clog2(DEPTH + PIPE + 1) + 1;

  logic [CW-1:0] issue_cnt;
  logic [LW-1:0] lat_cnt;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      issue_cnt <= '0;
      lat_cnt   <= '0;
    end else begin
      if (run_accept)  issue_cnt <= '0;
      else if (rd_en)  issue_cnt <= issue_cnt + 1'b1;
      if (run_accept)  lat_cnt <= '0;
      else if (busy)   lat_cnt <= lat_cnt + 1'b1;
    end
  end

  // R4
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n) done |=> !done);

  // R4
  latency_chk: assert property (@(posedge clk) disable iff (!rst_n) done |-> lat_cnt == LW'(DEPTH + PIPE));

  // R3
  issue_in_run_chk: assert property (@(posedge clk) disable iff (!rst_n) rd_en |-> busy);

  // R3
  addr_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && rd_addr != '0) |-> ($past(rd_en) && rd_addr == AW'($past(rd_addr) + 1'b1)));

  // R3
  issue_count_chk: assert property (@(posedge clk) disable iff (!rst_n) done |-> issue_cnt == CW'(DEPTH));

  // R5
  accept_busy_chk: assert property (@(posedge clk) disable iff (!rst_n) (start && !busy) |=> busy);

  // R5
  busy_end_chk: assert property (@(posedge clk) disable iff (!rst_n) $fell(busy) |-> done);

  // R6
  result_hold_chk: assert property (@(posedge clk) disable iff (!rst_n) !done |-> $stable(result));

endmodule

bind dp8_engine dp8_engine_chk #(.DW(DW), .DEPTH(DEPTH), .AW(AW), .PIPE(PIPE)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .start     (start),
  .run_accept(run_accept),
  .rd_en     (rd_en),
  .rd_addr   (rd_addr),
  .busy      (busy),
  .done      (done),
  .result    (result)
);

// File: tb/test_dp8_engine.sv
`timescale 1ns/1ps
module test_dp8_engine;

  localparam int N  = 64;
  localparam int L  = 8;
  localparam int DW = 32;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          start = 1'b0;
  logic [L*DW-1:0] data_bank_q = '0;
  logic [L*DW-1:0] coef_bank_q = '0;
  logic          rd_en;
  logic [2:0]    rd_addr;
  logic          busy;
  logic          done;
  logic [DW-1:0] result;

  logic [31:0] dmem [N];
  logic [31:0] cmem [N];

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  always #4 clk = ~clk;

  dp8_engine i_dp8_engine (
    .clk(clk), .rst_n(rst_n), .start(start),
    .data_bank_q(data_bank_q), .coef_bank_q(coef_bank_q),
    .rd_en(rd_en), .rd_addr(rd_addr), .busy(busy), .done(done), .result(result)
  );

  // Bank model: bank k stores elements 8k..8k+7, one-cycle read latency
  always @(posedge clk) begin
    if (rd_en) begin
      for (int k = 0; k < L; k++) begin
        data_bank_q[k*DW +: DW] <= dmem[k*8 + int'(rd_addr)];
        coef_bank_q[k*DW +: DW] <= cmem[k*8 + int'(rd_addr)];
      end
    end
  end

  task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  function automatic logic [31:0] model_dot();
    logic [31:0] s = 32'd0;
    for (int i = N - 1; i >= 0; i--) s = s + dmem[i] * cmem[i];
    return s;
  endfunction

  // One run with a cycle-by-cycle trace; optional stray start in mid-run
  task automatic run_trace(input string req, input bit poke);
    logic [31:0] exp;
    exp = model_dot();
    @(negedge clk) start = 1'b1;
    @(negedge clk) start = 1'b0;
    for (int k = 0; k <= 13; k++) begin
      if (k > 0) @(negedge clk);
      if (poke && k == 4) start = 1'b1;
      if (poke && k == 5) start = 1'b0;
      chk("R3", $sformatf("rd_en k=%0d", k), 32'(rd_en), 32'(k < 8));
      if (k < 8) chk("R3", $sformatf("rd_addr k=%0d", k), 32'(rd_addr), 32'(k));
      chk("R5", $sformatf("busy k=%0d", k), 32'(busy), 32'(k < 13));
      chk("R4", $sformatf("done k=%0d", k), 32'(done), 32'(k == 13));
    end
    chk(req, "result", result, exp);
  endtask

  task automatic t_reset();
    chk("R7", "busy", 32'(busy), 32'd0);
    chk("R7", "done", 32'(done), 32'd0);
    chk("R7", "rd_en", 32'(rd_en), 32'd0);
    chk("R7", "result", result, 32'd0);
  endtask

  task automatic t_ramp();
    for (int i = 0; i < N; i++) begin dmem[i] = 32'(i + 1); cmem[i] = 32'd1; end
    run_trace("R1", 1'b0);
    chk("R1", "ramp sum", result, 32'd2080);
  endtask

  task automatic t_partition();
    int pos [6] = '{0, 7, 8, 19, 56, 63};
    foreach (pos[n]) begin
      for (int i = 0; i < N; i++) begin
        dmem[i] = (i == pos[n]) ? 32'd1 : 32'd0;
        cmem[i] = 32'(3 * i + 5);
      end
      run_trace("R2", 1'b0);
      chk("R2", $sformatf("probe %0d", pos[n]), result, 32'(3 * pos[n] + 5));
    end
  endtask

  task automatic t_negative();
    for (int i = 0; i < N; i++) begin
      dmem[i] = -32'(i + 1);
      cmem[i] = (i % 2 == 1) ? -32'd3 : 32'd2;
    end
    run_trace("R9", 1'b0);
  endtask

  task automatic t_wrap();
    for (int i = 0; i < N; i++) begin dmem[i] = 32'h7fffffff; cmem[i] = 32'd1; end
    run_trace("R8", 1'b0);
    chk("R8", "sum wrap", result, 32'hffffffc0);
    for (int i = 0; i < N; i++) begin dmem[i] = 32'h7fffffff; cmem[i] = 32'h7fffffff; end
    run_trace("R8", 1'b0);
    chk("R8", "product wrap", result, 32'd64);
  endtask

  task automatic t_midstart();
    for (int i = 0; i < N; i++) begin dmem[i] = 32'(i * 7 - 100); cmem[i] = 32'(50 - i); end
    run_trace("R5", 1'b1);
  endtask

  task automatic t_hold_and_clear();
    logic [31:0] held;
    held = result;
    for (int i = 0; i < N; i++) begin dmem[i] = 32'(i); cmem[i] = 32'(i); end
    repeat (20) @(negedge clk);
    chk("R6", "done idle", 32'(done), 32'd0);
    chk("R6", "result held", result, held);
    run_trace("R6", 1'b0);
    chk("R6", "fresh run", result, 32'd85344);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_ramp();
    t_partition();
    t_negative();
    t_wrap();
    t_midstart();
    t_hold_and_clear();
    finished = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule